// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block is a memory-mapped SPI master engine. It pulls one word at a time from an external transmit queue, shifts it out on MOSI as a frame of 1 to 32 bits, and pushes the word it samples on MISO into an external receive queue. The queue storage and the interrupt masking live in neighbouring blocks; this block owns the register file, the serial clock generation and the burst logic.

A burst is a programmed number of frames. Software writes the control register with the enable bit and a frame count, then feeds the transmit queue. The single active-low chip select either stays low for the whole burst or is released after each frame. Only when the count runs out do the completion flags rise in the status register and in the raw interrupt register; the count then reloads from the control field, ready for the next burst.

Registers are 32-bit words at word addresses: 0 control, 1 frame size, 2 status (read-only), 3 interrupt clear (write-only), 4 clock divider, 5 raw interrupt (read-only). The clear register reads as zero.

Top module: `spi_frame_seq`

## Requirements
- R1: A frame starts, popping exactly one word from the transmit queue, only when control bit 0 (enable) is 1, the transmit queue is not empty and the remaining frame count is nonzero; otherwise the queue is left untouched and chip select stays high.
- R2: The remaining frame count is loaded from control bits [23:8] on every control write without bit 31. Each completed frame lowers it by one. When it reaches zero it is reloaded from control bits [23:8].
- R3: With control bit 26 set, chip select goes low at the first frame and stays low between frames until the count is exhausted. With bit 26 clear, chip select returns high after every frame.
- R4: When the last frame of a burst completes, chip select goes high and bits 0 (transmit done) and 1 (receive ready) are set in both the status register and the raw interrupt register; raw interrupt bits [1:0] also drive the `irq_raw` output.
- R5: Status bits 0 and 1 are cleared when a frame starts. Status bit 14 is 1 while a frame shifts, and status bit 12 is a one-cycle pulse in the cycle after a frame starts.
- R6: The frame size is register bits [5:0]. A write of 0 or of a value above 32 is dropped, and so is any size write made while control bit 0 is 1.
- R7: SCK idles low. Each SCK high or low phase lasts (divider value + 1) system clock cycles.
- R8: Frames use SPI mode 0, most significant bit first. Only the low (size) bits of the transmit word are sent. The received word holds the sampled bits in arrival order in its low (size) bits, with zeros above.
- R9: Writing 1 to bit 0 or bit 1 of the interrupt clear register clears that raw interrupt bit; a zero leaves it. If a burst completes in the same cycle as a clear, the bits end up set.
- R10: After reset, or after a control write with bit 31 set, control reads 0x80000102, size 4, divider 7, raw interrupt 0, the frame count is 1 and the controller is disabled.
- R11: Status bit 13 reads the chip select level, bit 10 reads transmit queue empty and bit 6 reads receive queue empty; the idle status after reset is 0x2440 with both queues empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| txq_empty | input | 1 | Transmit queue is empty |
| txq_data | input | 32 | Head word of the transmit queue |
| txq_pop | output | 1 | Removes the head word of the transmit queue |
| rxq_empty | input | 1 | Receive queue is empty (status only) |
| rxq_push | output | 1 | Writes `rxq_data` into the receive queue |
| rxq_data | output | 32 | Word received in the completing frame |
| irq_raw | output | 2 | Raw interrupt bits: [0] transmit done, [1] receive ready |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The last frame of a burst sets the raw interrupt bits on the same clock edge at which software may write the interrupt clear register, and the two must not cancel into a lost event. The bench provokes this with a one-bit frame and a divider of zero, so the completing edge falls exactly two clocks after the start edge, and it holds a clear write on that edge. It then reads the raw register: both bits must be set, which shows that the completion event takes priority over the clear.

// File: rtl/spi_seq_pkg.sv
// Package: shared constants for the SPI burst sequencer.
// Assumes a 32-bit register bus with word addresses.
package spi_seq_pkg;
    localparam int FRAME_MAX = 32;
    localparam int SIZE_W    = 6;
    localparam int CNT_W     = 16;
    localparam int CNT_LSB   = 8;
    localparam int EN_BIT    = 0;
    localparam int HOLD_BIT  = 26;
    localparam int SRST_BIT  = 31;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SIZE = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_ICLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLKG = 3'd4;
    localparam logic [ADDR_W-1:0] A_RAW  = 3'd5;

    localparam logic [31:0]       CTRL_RST = 32'h8000_0102;
    localparam logic [SIZE_W-1:0] SIZE_RST = 6'd4;

    localparam int ST_TXDONE = 0;
    localparam int ST_RXRDY  = 1;
    localparam int ST_RXEMP  = 6;
    localparam int ST_TXEMP  = 10;
    localparam int ST_FSTART = 12;
    localparam int ST_SEL    = 13;
    localparam int ST_ACTIVE = 14;

    typedef enum logic {SQ_IDLE, SQ_SHIFT} seq_state_e;
endpackage

// File: rtl/spi_seq_clkdiv.sv
// Module: half-period tick generator for SCK.
// Emits one tick every (div + 1) cycles while run is high; restarts when run drops.
module spi_seq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Purpose: count cycles of one SCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt <= '0;
        else if (cnt == div)       cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    // R7: the phase counter never runs past the divider value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (cnt <= div) || $changed(div));
endmodule

// File: rtl/spi_seq_shift.sv
// Module: mode-0 frame shifter, MSB first, 1..W bits per frame.
// Assumes tick arrives at each SCK phase boundary while busy.
module spi_seq_shift #(
    parameter int W     = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic [W-1:0]     tx_word,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [W-1:0]     rx_word
);
    logic [W-1:0]     tx_sh;
    logic [W-1:0]     rx_sh;
    logic [LEN_W-1:0] bitcnt;
    logic [LEN_W-1:0] len_q;
    logic             last_bit;

    assign last_bit = (bitcnt == len_q - 1'b1);
    assign done     = busy && tick && sck && last_bit;
    assign mosi     = busy ? tx_sh[W-1] : 1'b0;
    assign rx_word  = rx_sh;

    // Purpose: load a frame, then sample on rising and shift on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0; sck <= 1'b0; tx_sh <= '0; rx_sh <= '0;
            bitcnt <= '0; len_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            sck    <= 1'b0;
            tx_sh  <= tx_word << (W - int'(len));
            rx_sh  <= '0;
            bitcnt <= '0;
            len_q  <= len;
        end else if (busy && tick) begin
            if (!sck) begin
                sck   <= 1'b1;
                rx_sh <= {rx_sh[W-2:0], miso};
            end else begin
                sck <= 1'b0;
                if (last_bit) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                    tx_sh  <= {tx_sh[W-2:0], 1'b0};
                end
            end
        end
    end

    // R7: SCK rests low outside a frame
    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // R8: MOSI does not move across a rising SCK edge
    p_mosi_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(sck)) |-> $stable(mosi));
endmodule

// File: rtl/spi_seq_ctrl.sv
// Module: burst sequencer: frame count, chip select and completion flags.
// Assumes the shifter reports done for one cycle at the end of every frame.
module spi_seq_ctrl
    import spi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             en,
    input  logic             hold,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] ctrl_cnt,
    input  logic             txq_empty,
    input  logic             shift_done,
    output logic             start,
    output logic             last_evt,
    output logic             cs_n,
    output logic             txdone,
    output logic             rxrdy,
    output logic             fstart
);
    seq_state_e       st;
    logic [CNT_W-1:0] cnt;

    assign start    = (st == SQ_IDLE) && en && !txq_empty && (cnt != '0);
    assign last_evt = shift_done && (cnt == CNT_W'(1));

    // Purpose: frame state, chip select and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st <= SQ_IDLE; cs_n <= 1'b1;
            txdone <= 1'b0; rxrdy <= 1'b0; fstart <= 1'b0;
        end else begin
            fstart <= start;
            if (start) begin
                st <= SQ_SHIFT; cs_n <= 1'b0;
                txdone <= 1'b0; rxrdy <= 1'b0;
            end else if (shift_done) begin
                st <= SQ_IDLE;
                if (last_evt) begin
                    cs_n <= 1'b1; txdone <= 1'b1; rxrdy <= 1'b1;
                end else if (!hold) begin
                    cs_n <= 1'b1;
                end
            end
        end
    end

    // Purpose: remaining frame count with load, decrement and reload.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) cnt <= CNT_W'(1);
        else if (ctrl_wr)       cnt <= wr_cnt;
        else if (last_evt)      cnt <= ctrl_cnt;
        else if (shift_done)    cnt <= cnt - 1'b1;
    end

    // R2: a non-final frame lowers the count by exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_done && !last_evt && !ctrl_wr && !soft_rst) |=> (cnt == $past(cnt) - 1'b1));
    // R3: pulsed mode releases select after each frame
    p_pulse_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_done && !hold && !soft_rst) |=> cs_n);
    // R4: burst end releases select and raises both flags
    p_burst_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && !soft_rst) |=> (cs_n && txdone && rxrdy));
    // R5: frame start indication lasts one cycle
    p_fstart_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> !fstart);
endmodule

// File: rtl/spi_seq_regs.sv
// Module: register file: control, size, divider, status read and raw interrupts.
// Assumes single-cycle writes; reads are combinational and side-effect free.
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              st_txdone,
    input  logic              st_rxrdy,
    input  logic              st_fstart,
    input  logic              st_cs_n,
    input  logic              st_busy,
    input  logic              txq_empty,
    input  logic              rxq_empty,
    input  logic              set_evt,
    output logic              soft_rst,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [CNT_W-1:0]  ctrl_cnt,
    output logic              ctrl_en,
    output logic              ctrl_hold,
    output logic [SIZE_W-1:0] size_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [1:0]        raw
);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(7);

    logic [31:0]       ctrl_q;
    logic [SIZE_W-1:0] wsize;
    logic              size_ok;
    logic [1:0]        clr_mask;
    logic [31:0]       status;

    assign soft_rst  = wr && (addr == A_CTRL) && wdata[SRST_BIT];
    assign ctrl_wr   = wr && (addr == A_CTRL) && !wdata[SRST_BIT];
    assign wr_cnt    = wdata[CNT_LSB +: CNT_W];
    assign ctrl_cnt  = ctrl_q[CNT_LSB +: CNT_W];
    assign ctrl_en   = ctrl_q[EN_BIT];
    assign ctrl_hold = ctrl_q[HOLD_BIT];
    assign wsize     = wdata[SIZE_W-1:0];
    assign size_ok   = !ctrl_en && (wsize != '0) && (wsize <= SIZE_W'(FRAME_MAX));
    assign clr_mask  = (wr && addr == A_ICLR) ? wdata[1:0] : 2'b00;

    // Purpose: writable registers with soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTRL_RST; size_q <= SIZE_RST; div_q <= DIV_RST;
        end else if (wr) begin
            case (addr)
                A_CTRL:  ctrl_q <= wdata;
                A_SIZE:  if (size_ok) size_q <= wsize;
                A_CLKG:  div_q <= wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: raw interrupt bits; completion outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) raw <= 2'b00;
        else                    raw <= (raw & ~clr_mask) | {2{set_evt}};
    end

    // Purpose: assemble the status word.
    always_comb begin
        status            = '0;
        status[ST_TXDONE] = st_txdone;
        status[ST_RXRDY]  = st_rxrdy;
        status[ST_RXEMP]  = rxq_empty;
        status[ST_TXEMP]  = txq_empty;
        status[ST_FSTART] = st_fstart;
        status[ST_SEL]    = st_cs_n;
        status[ST_ACTIVE] = st_busy;
    end

    // Purpose: read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_SIZE:  rdata = 32'(size_q);
            A_STAT:  rdata = status;
            A_CLKG:  rdata = 32'(div_q);
            A_RAW:   rdata = 32'(raw);
            default: rdata = '0;
        endcase
    end

    // R6: a size write while enabled leaves the size unchanged
    p_size_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SIZE && ctrl_en) |=> $stable(size_q));
    // R9: completion in the same cycle as a clear leaves both bits set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !soft_rst) |=> (raw == 2'b11));
endmodule

// File: rtl/spi_frame_seq.sv
// Module: top of the SPI burst sequencer.
// Assumes first-word-fall-through queues outside: txq_data is valid whenever
// txq_empty is low, and a pop or push takes effect on the clock edge.
module spi_frame_seq
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txq_empty,
    input  logic [31:0]       txq_data,
    output logic              txq_pop,
    input  logic              rxq_empty,
    output logic              rxq_push,
    output logic [31:0]       rxq_data,
    output logic [1:0]        irq_raw,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic              soft_rst, ctrl_wr, ctrl_en, ctrl_hold;
    logic [CNT_W-1:0]  wr_cnt, ctrl_cnt;
    logic [SIZE_W-1:0] size_q;
    logic [DIV_W-1:0]  div_q;
    logic              start, last_evt, txdone, rxrdy, fstart;
    logic              busy, tick, done;

    spi_seq_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .st_txdone(txdone), .st_rxrdy(rxrdy), .st_fstart(fstart),
        .st_cs_n(spi_cs_n), .st_busy(busy),
        .txq_empty(txq_empty), .rxq_empty(rxq_empty), .set_evt(last_evt),
        .soft_rst(soft_rst), .ctrl_wr(ctrl_wr), .wr_cnt(wr_cnt),
        .ctrl_cnt(ctrl_cnt), .ctrl_en(ctrl_en), .ctrl_hold(ctrl_hold),
        .size_q(size_q), .div_q(div_q), .raw(irq_raw)
    );

    spi_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(ctrl_en),
        .hold(ctrl_hold), .ctrl_wr(ctrl_wr), .wr_cnt(wr_cnt),
        .ctrl_cnt(ctrl_cnt), .txq_empty(txq_empty), .shift_done(done),
        .start(start), .last_evt(last_evt), .cs_n(spi_cs_n),
        .txdone(txdone), .rxrdy(rxrdy), .fstart(fstart)
    );

    spi_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(busy),
        .div(div_q), .tick(tick)
    );

    spi_seq_shift #(.W(FRAME_MAX), .LEN_W(SIZE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .start(start),
        .tx_word(txq_data), .len(size_q), .tick(tick), .miso(spi_miso),
        .busy(busy), .sck(spi_sck), .mosi(spi_mosi), .done(done),
        .rx_word(rxq_data)
    );

    assign txq_pop  = start;
    assign rxq_push = done;

    // R1: a pop opens a frame with select low and the shifter running
    p_pop_opens_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (txq_pop && !soft_rst) |=> (busy && !spi_cs_n));
    // R3: select is low whenever a frame is shifting
    p_cs_during_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !spi_cs_n);
endmodule

// File: tb/spi_frame_seq_tb.sv
// Directed bench for spi_frame_seq. MISO is MOSI inverted, so each received
// word is the complement of the sent bits.
module spi_frame_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        txq_empty, txq_pop, rxq_empty, rxq_push;
    logic [31:0] txq_data, rxq_data;
    logic [1:0]  irq_raw;
    logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

    logic [31:0] txq [0:63];
    int tx_wr = 0;
    int tx_rd = 0;

    int n_checks = 0;
    int n_fail   = 0;

    // monitor state
    logic [31:0] cap_mosi [0:63];
    logic [31:0] cap_rx   [0:63];
    int          n_cap = 0;
    logic [31:0] acc = '0;
    logic        prev_sck = 1'b0;
    logic        prev_cs  = 1'b1;
    int          cs_falls = 0;
    int          cs_rises = 0;
    int          hi_run   = 0;
    int          last_hi  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign txq_empty = (tx_rd == tx_wr);
    assign txq_data  = txq[tx_rd[5:0]];
    assign spi_miso  = ~spi_mosi;

    spi_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txq_empty(txq_empty), .txq_data(txq_data), .txq_pop(txq_pop),
        .rxq_empty(rxq_empty), .rxq_push(rxq_push), .rxq_data(rxq_data),
        .irq_raw(irq_raw), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always @(posedge clk) if (txq_pop) tx_rd <= tx_rd + 1;

    // Monitor: capture MOSI at SCK rises, frames at pushes, select edges, SCK high time
    always @(negedge clk) begin
        if (spi_sck && !prev_sck) acc = {acc[30:0], spi_mosi};
        if (spi_sck) hi_run = hi_run + 1;
        if (!spi_sck && prev_sck) begin last_hi = hi_run; hi_run = 0; end
        if (rxq_push) begin
            cap_mosi[n_cap[5:0]] = acc;
            cap_rx[n_cap[5:0]]   = rxq_data;
            n_cap = n_cap + 1;
            acc = '0;
        end
        if (!spi_cs_n && prev_cs) cs_falls = cs_falls + 1;
        if (spi_cs_n && !prev_cs) cs_rises = cs_rises + 1;
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] w);
        txq[tx_wr[5:0]] = w;
        tx_wr = tx_wr + 1;
    endtask

    task automatic wait_frames(input int target);
        int guard = 0;
        while (n_cap < target && guard < 5000) begin tick(); guard++; end
        if (n_cap < target) check("wait", 32'(n_cap), 32'(target));
        tick(); tick();
    endtask

    function automatic logic [31:0] msk(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    endfunction

    // Reset state and idle status (R10, R11)
    task automatic t_reset();
        logic [31:0] v;
        rd_reg(3'd0, v); check("R10 ctrl", v, 32'h8000_0102);
        rd_reg(3'd1, v); check("R10 size", v, 32'd4);
        rd_reg(3'd4, v); check("R10 div", v, 32'd7);
        rd_reg(3'd5, v); check("R10 raw", v, 32'd0);
        rd_reg(3'd2, v); check("R11 status idle", v, 32'h2440);
        check("R10 cs_n", 32'(spi_cs_n), 32'd1);
    endtask

    // Size register acceptance (R6)
    task automatic t_size();
        logic [31:0] v;
        wr_reg(3'd1, 32'd40); rd_reg(3'd1, v); check("R6 size>32 dropped", v, 32'd4);
        wr_reg(3'd1, 32'd0);  rd_reg(3'd1, v); check("R6 size 0 dropped", v, 32'd4);
        wr_reg(3'd1, 32'd8);  rd_reg(3'd1, v); check("R6 size 8 taken", v, 32'd8);
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd1, 32'd16); rd_reg(3'd1, v); check("R6 write while enabled", v, 32'd8);
        wr_reg(3'd0, 32'h0);
    endtask

    // Pulsed select, counting, completion, reload (R1 R2 R3 R4 R5 R7 R8 R9)
    task automatic t_pulsed();
        logic [31:0] v;
        int base = n_cap;
        int f0   = cs_falls;
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd0, 32'h0000_0301);
        push(32'h1234_56A5); push(32'h0000_003C);
        wait_frames(base + 2);
        check("R4 no flags mid-burst", 32'(irq_raw), 32'd0);
        check("R3 pulsed cs high", 32'(spi_cs_n), 32'd1);
        rd_reg(3'd2, v); check("R4 status mid-burst", v & 32'h3, 32'd0);
        push(32'h0000_000F);
        wait_frames(base + 3);
        check("R4 raw at end", 32'(irq_raw), 32'd3);
        rd_reg(3'd2, v); check("R4 status at end", v & 32'h3, 32'd3);
        check("R3 one select per frame", 32'(cs_falls - f0), 32'd3);
        check("R8 mosi f0", cap_mosi[base[5:0]], 32'hA5);
        check("R8 mosi f1", cap_mosi[6'(base+1)], 32'h3C);
        check("R8 rx f0", cap_rx[base[5:0]], 32'h5A);
        check("R8 rx f2", cap_rx[6'(base+2)], 32'hF0);
        check("R7 sck high div1", 32'(last_hi), 32'd2);
        wr_reg(3'd3, 32'h1);
        check("R9 clear bit0 only", 32'(irq_raw), 32'd2);
        wr_reg(3'd3, 32'h2);
        check("R9 clear bit1", 32'(irq_raw), 32'd0);
        push(32'h81);
        wait_frames(base + 4);
        check("R2 count reloaded to 3", 32'(irq_raw), 32'd0);
        rd_reg(3'd2, v); check("R5 done cleared at start", v & 32'h3, 32'd0);
        push(32'h01); push(32'h02);
        wait_frames(base + 6);
        check("R2 second burst ends", 32'(irq_raw), 32'd3);
        wr_reg(3'd3, 32'h3);
    endtask

    // Held select across a burst (R3 R4 R8 R11)
    task automatic t_held();
        logic [31:0] v;
        int base = n_cap;
        int f0 = cs_falls;
        int r0 = cs_rises;
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'd12);
        wr_reg(3'd0, 32'h0400_0201);
        push(32'h0000_0ABC);
        wait_frames(base + 1);
        check("R3 held cs low between", 32'(spi_cs_n), 32'd0);
        rd_reg(3'd2, v); check("R11 status select bit", (v >> 13) & 32'h1, 32'd0);
        push(32'hFFFF_F123);
        wait_frames(base + 2);
        check("R3 held cs released", 32'(spi_cs_n), 32'd1);
        check("R3 held one fall", 32'(cs_falls - f0), 32'd1);
        check("R3 held one rise", 32'(cs_rises - r0), 32'd1);
        check("R8 mosi 12b", cap_mosi[6'(base+1)], 32'h123);
        check("R8 rx 12b", cap_rx[base[5:0]], 32'h543);
        check("R4 held raw", 32'(irq_raw), 32'd3);
        wr_reg(3'd3, 32'h3);
    endtask

    // Active flag and slow SCK (R5 R7)
    task automatic t_active();
        logic [31:0] v;
        int base = n_cap;
        wr_reg(3'd4, 32'd9);
        wr_reg(3'd0, 32'h0000_0101);
        push(32'h0000_0555);
        tick(); tick(); tick();
        rd_reg(3'd2, v);
        check("R5 active while shifting", (v >> 14) & 32'h1, 32'd1);
        check("R5 done low while shifting", v & 32'h3, 32'd0);
        wait_frames(base + 1);
        rd_reg(3'd2, v);
        check("R5 active after frame", (v >> 14) & 32'h1, 32'd0);
        check("R7 sck high div9", 32'(last_hi), 32'd10);
        wr_reg(3'd3, 32'h3);
    endtask

    // Start conditions (R1 R11)
    task automatic t_gating();
        logic [31:0] v;
        int base = n_cap;
        wr_reg(3'd0, 32'h0000_0100);
        push(32'h0000_0055);
        repeat (20) tick();
        check("R1 disabled no pop", 32'(tx_wr - tx_rd), 32'd1);
        check("R1 disabled cs high", 32'(spi_cs_n), 32'd1);
        rd_reg(3'd2, v); check("R11 tx not empty", (v >> 10) & 32'h1, 32'd0);
        wr_reg(3'd0, 32'h0000_0001);
        repeat (20) tick();
        check("R1 zero count no pop", 32'(tx_wr - tx_rd), 32'd1);
        wr_reg(3'd0, 32'h0000_0101);
        wait_frames(base + 1);
        check("R1 enabled pops", 32'(tx_wr - tx_rd), 32'd0);
        wr_reg(3'd3, 32'h3);
    endtask

    // Extreme frame sizes (R6 R8)
    task automatic t_extremes();
        int base = n_cap;
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd1, 32'd32);
        wr_reg(3'd0, 32'h0000_0101);
        push(32'hDEAD_BEEF);
        wait_frames(base + 1);
        check("R8 mosi 32b", cap_mosi[base[5:0]], 32'hDEAD_BEEF);
        check("R8 rx 32b", cap_rx[base[5:0]], ~32'hDEAD_BEEF & msk(32));
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'd1);
        wr_reg(3'd0, 32'h0000_0101);
        push(32'h0000_0003);
        wait_frames(base + 2);
        check("R8 mosi 1b", cap_mosi[6'(base+1)], 32'h1);
        check("R8 rx 1b", cap_rx[6'(base+1)], 32'h0);
        wr_reg(3'd3, 32'h3);
    endtask

    // Completion and clear on the same edge (R9)
    task automatic t_collide();
        logic [31:0] v;
        check("R9 raw clear before", 32'(irq_raw), 32'd0);
        push(32'h1);
        tick(); tick();
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h3;
        tick();
        reg_wr = 1'b0;
        check("R9 set wins over clear", 32'(irq_raw), 32'd3);
        rd_reg(3'd2, v); check("R4 status after collide", v & 32'h3, 32'd3);
    endtask

    // Soft reset (R10 R11)
    task automatic t_softrst();
        logic [31:0] v;
        wr_reg(3'd0, 32'h8000_0000);
        rd_reg(3'd0, v); check("R10 soft ctrl", v, 32'h8000_0102);
        rd_reg(3'd1, v); check("R10 soft size", v, 32'd4);
        rd_reg(3'd4, v); check("R10 soft div", v, 32'd7);
        check("R10 soft raw", 32'(irq_raw), 32'd0);
        rd_reg(3'd2, v); check("R11 soft status", v, 32'h2440);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rxq_empty = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_size();
        t_pulsed();
        t_held();
        t_active();
        t_gating();
        t_extremes();
        t_collide();
        t_softrst();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule